// File: doc/BRIEF.md
# DRAM Access State Sequencer

This block runs a single DRAM read or write access as a fixed series of bus states: a precharge state, a row state, zero to three row-hold wait states, and two column states. It multiplexes the row and column halves of a request address onto one DRAM address bus. It drives active-low row and column strobes, an active-low write enable, and a data-bus drive enable. It samples read data at the end of the last column state.

A CPU-side master raises `req` with an address, a direction and write data. The block accepts the request only while it is idle. It pulses `ack` for one cycle when the access completes, and `rdata` carries the sampled read data at that moment. Two configuration inputs are captured when a request is accepted. `cfg_ras_early` picks where the row strobe falls inside the row state. `cfg_rcd` sets how many row-hold states are inserted, which lengthens the time the row address is held after the row strobe falls.

Top module: `dram_access_seq`

## Requirements
- R1: After reset `ras_n`, `cas_n` and `we_n` are 1, and `dq_oe`, `ack` and `ma` are 0.
- R2: An accepted access occupies precharge (1 cycle), row (1 cycle), N hold cycles, column-1 (1 cycle) and column-2 (1 cycle). `ack` is 1 in the cycle after column-2, so `ack` rises 4+N clock edges after the accepting edge.
- R3: With `cfg_ras_early`=1, `ras_n` is 0 from the start of the row state.
- R4: With `cfg_ras_early`=0, `ras_n` stays 1 for the first half of the row state and goes to 0 at the falling clock edge in the middle of it.
- R5: `ras_n` is 1 during idle and precharge. Once asserted, it stays 0 until the end of column-2.
- R6: N equals `cfg_rcd` (0 to 3). Through precharge, row and every hold state, `ma` carries the row address unchanged.
- R7: In column-1 and column-2, `ma` carries the column address. In idle, `ma` is 0.
- R8: `cas_n` is 0 exactly during column-2, for reads and writes alike.
- R9: For a write (`req_write`=1), `we_n` is 0 and `dq_oe` is 1 exactly during column-1 and column-2, with `dq_out` equal to the write data. For a read, `we_n` stays 1 and `dq_oe` stays 0.
- R10: For a read, `rdata` equals the value on `dq_in` at the clock edge that ends column-2, and it is valid while `ack` is 1.
- R11: `ack` is a one-cycle pulse. A request is accepted only in idle, so `req` and new request fields presented during an access leave that access unchanged.
- R12: The row address is `req_addr[ROW_W+COL_W-1:COL_W]` and the column address is `req_addr[COL_W-1:0]`. Each is zero-extended to the bus width max(ROW_W, COL_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, accepted in idle |
| req_addr | input | ROW_W+COL_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| cfg_ras_early | input | 1 | 1 = row strobe at row-state start, 0 = at mid-state falling edge |
| cfg_rcd | input | 2 | Number of row-hold states (0 to 3) |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data captured at end of column-2 |
| ma | output | max(ROW_W,COL_W) | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_oe | output | 1 | Data bus drive enable |
| dq_out | output | DATA_W | Data driven to DRAM |
| dq_in | input | DATA_W | Data from DRAM |

## Verification
On every cycle the assertions check the following:
- the row address stays still through the hold states;
- the row strobe is high in precharge and low in the column states;
- the column strobe is never low without the row strobe;
- the write enable always matches the bus drive enable;
- `ack` is a single pulse that follows a column strobe;
- a precharge can only follow idle.

The exact cycle counts per hold setting, the half-cycle position of the late row strobe, the address slicing, the sampled read value, and the rejection of a request during a busy access are shown only by the bench's sweep over every hold count, strobe option and direction.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_ROW  = 3'd2,
      ST_HOLD = 3'd3,
      ST_COL1 = 3'd4,
      ST_COL2 = 3'd5
   } dseq_state_e;

endpackage

// File: rtl/dseq_fsm.sv
module dseq_fsm
   import dram_seq_pkg::*;
#(
   parameter int RCD_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [RCD_W-1:0] rcd,
   output logic             accept,
   output dseq_state_e      st,
   output logic             ack
);

   logic [RCD_W-1:0] hold_cnt;

   assign accept = (st == ST_IDLE) && req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         hold_cnt <= '0;
         ack      <= 1'b0;
      end else begin
         ack <= (st == ST_COL2);
         unique case (st)
            ST_IDLE: if (req) st <= ST_PRE;
            ST_PRE:  st <= ST_ROW;
            ST_ROW: begin
               if (rcd == '0) begin
                  st <= ST_COL1;
               end else begin
                  st       <= ST_HOLD;
                  hold_cnt <= {{(RCD_W-1){1'b0}}, 1'b1};
               end
            end
            ST_HOLD: begin
               if (hold_cnt == rcd) st <= ST_COL1;
               else                 hold_cnt <= hold_cnt + 1'b1;
            end
            ST_COL1: st <= ST_COL2;
            ST_COL2: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dseq_addr_mux.sv
module dseq_addr_mux
   import dram_seq_pkg::*;
#(
   parameter int ROW_W = 8,
   parameter int COL_W = 8,
   parameter int MA_W  = 8
) (
   input  logic [ROW_W+COL_W-1:0] addr_q,
   input  dseq_state_e            st,
   output logic [MA_W-1:0]        ma
);

   logic [MA_W-1:0] row_ext;
   logic [MA_W-1:0] col_ext;

   generate
      if (ROW_W == MA_W) begin : g_row_full
         assign row_ext = addr_q[ROW_W+COL_W-1:COL_W];
      end else begin : g_row_pad
         assign row_ext = {{(MA_W-ROW_W){1'b0}}, addr_q[ROW_W+COL_W-1:COL_W]};
      end
      if (COL_W == MA_W) begin : g_col_full
         assign col_ext = addr_q[COL_W-1:0];
      end else begin : g_col_pad
         assign col_ext = {{(MA_W-COL_W){1'b0}}, addr_q[COL_W-1:0]};
      end
   endgenerate

   always_comb begin
      unique case (st)
         ST_PRE, ST_ROW, ST_HOLD: ma = row_ext;
         ST_COL1, ST_COL2:        ma = col_ext;
         default:                 ma = '0;
      endcase
   end

endmodule

// File: rtl/dseq_strobes.sv
module dseq_strobes
   import dram_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  dseq_state_e st,
   input  logic        early_q,
   input  logic        write_q,
   output logic        ras_n,
   output logic        cas_n,
   output logic        we_n,
   output logic        dq_oe
);

   logic ras_mid_q;
   logic ras_on;
   logic col_phase;

   // Half-cycle flag: set at the falling edge inside the row state.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) ras_mid_q <= 1'b0;
      else        ras_mid_q <= (st == ST_ROW);
   end

   assign col_phase = (st == ST_COL1) || (st == ST_COL2);
   assign ras_on    = (st == ST_HOLD) || col_phase ||
                      ((st == ST_ROW) && (early_q || ras_mid_q));

   assign ras_n = !ras_on;
   assign cas_n = !(st == ST_COL2);
   assign dq_oe = write_q && col_phase;
   assign we_n  = !(write_q && col_phase);

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
   import dram_seq_pkg::*;
#(
   parameter int ROW_W  = 8,
   parameter int COL_W  = 8,
   parameter int DATA_W = 16,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cfg_ras_early,
   input  logic [1:0]        cfg_rcd,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic [MA_W-1:0]   ma,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   input  logic [DATA_W-1:0] dq_in
);

   localparam int RCD_W = 2;

   generate
      if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("dram_access_seq: widths must be at least 1");
      end
   endgenerate

   dseq_state_e       st;
   logic              accept;
   logic [ADDR_W-1:0] addr_q;
   logic              write_q;
   logic              early_q;
   logic [RCD_W-1:0]  rcd_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         write_q <= 1'b0;
         early_q <= 1'b0;
         rcd_q   <= '0;
         wdata_q <= '0;
         rdata   <= '0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            early_q <= cfg_ras_early;
            rcd_q   <= cfg_rcd;
            wdata_q <= req_wdata;
         end
         if (st == ST_COL2 && !write_q) rdata <= dq_in;
      end
   end

   assign dq_out = wdata_q;

   dseq_fsm #(.RCD_W(RCD_W)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .rcd    (rcd_q),
      .accept (accept),
      .st     (st),
      .ack    (ack)
   );

   dseq_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_mux (
      .addr_q (addr_q),
      .st     (st),
      .ma     (ma)
   );

   dseq_strobes u_strobes (
      .clk     (clk),
      .rst_n   (rst_n),
      .st      (st),
      .early_q (early_q),
      .write_q (write_q),
      .ras_n   (ras_n),
      .cas_n   (cas_n),
      .we_n    (we_n),
      .dq_oe   (dq_oe)
   );

endmodule

// File: rtl/dseq_checker.sv
module dseq_checker
   import dram_seq_pkg::*;
#(
   parameter int MA_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input dseq_state_e     st,
   input logic [MA_W-1:0] ma,
   input logic            ras_n,
   input logic            cas_n,
   input logic            we_n,
   input logic            dq_oe,
   input logic            ack
);

   assert_row_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD) |-> (ma == $past(ma)));

   assert_ras_high_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PRE) |-> ras_n);

   assert_ras_low_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COL1 || st == ST_COL2) |-> !ras_n);

   assert_cas_needs_ras_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   assert_we_matches_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we_n == !dq_oe));

   assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   assert_ack_after_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(!cas_n));

   assert_pre_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PRE) |-> ($past(st) == ST_IDLE));

endmodule

bind dram_access_seq dseq_checker #(.MA_W(MA_W)) u_dseq_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .st    (st),
   .ma    (ma),
   .ras_n (ras_n),
   .cas_n (cas_n),
   .we_n  (we_n),
   .dq_oe (dq_oe),
   .ack   (ack)
);

// File: tb/test_dram_access_seq.sv
`timescale 1ns/1ps
module test_dram_access_seq;

   localparam int ROW_W  = 8;
   localparam int COL_W  = 6;
   localparam int DATA_W = 8;
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int MA_W   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              cfg_ras_early = 1'b0;
   logic [1:0]        cfg_rcd = 2'd0;
   logic              ack;
   logic [DATA_W-1:0] rdata;
   logic [MA_W-1:0]   ma;
   logic              ras_n, cas_n, we_n, dq_oe;
   logic [DATA_W-1:0] dq_out;
   logic [DATA_W-1:0] dq_in = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2 clk = ~clk;

   dram_access_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_dram_access_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
      .req_write(req_write), .req_wdata(req_wdata),
      .cfg_ras_early(cfg_ras_early), .cfg_rcd(cfg_rcd),
      .ack(ack), .rdata(rdata), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .dq_oe(dq_oe), .dq_out(dq_out), .dq_in(dq_in)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run_access(input int rcd, input bit early, input bit wr, input int n);
      int row, col, wd, rd, alt;
      row = (8'hA5 ^ (n * 37)) & 8'hFF;
      col = (6'h2A ^ (n * 11)) & 6'h3F;
      wd  = (n * 29 + 5) & 8'hFF;
      rd  = (n * 7 + 3) & 8'hFF;
      alt = (~((row << COL_W) | col)) & ((1 << ADDR_W) - 1);
      @(negedge clk);
      req           = 1'b1;
      req_addr      = ADDR_W'((row << COL_W) | col);
      req_write     = wr;
      req_wdata     = DATA_W'(wd);
      cfg_ras_early = early;
      cfg_rcd       = 2'(rcd);
      @(posedge clk);
      for (int k = 0; k <= 4 + rcd; k++) begin
         #1;
         if (k == 0) begin
            // R11: a fresh request shown while busy must not disturb the access
            req_addr      = ADDR_W'(alt);
            req_write     = !wr;
            cfg_ras_early = !early;
            cfg_rcd       = 2'(3 - rcd);
         end
         if (k == 2) req = 1'b0;
         if (k == 3 + rcd) dq_in = DATA_W'(rd);
         if (k == 4 + rcd) dq_in = DATA_W'(~rd);
         // R2 / R11: ack only after column-2
         chk("R2 ack timing", int'(ack), (k == 4 + rcd) ? 1 : 0);
         // R3 / R5: row strobe in first half of cycle
         if (k == 1)
            chk(early ? "R3 ras early" : "R4 ras late first half", int'(ras_n), early ? 0 : 1);
         else
            chk("R5 ras level", int'(ras_n), (k >= 2 && k <= 3 + rcd) ? 0 : 1);
         chk("R8 cas", int'(cas_n), (k == 3 + rcd) ? 0 : 1);
         chk("R9 we_n", int'(we_n), (wr && (k == 2 + rcd || k == 3 + rcd)) ? 0 : 1);
         chk("R9 dq_oe", int'(dq_oe), (wr && (k == 2 + rcd || k == 3 + rcd)) ? 1 : 0);
         if (wr && (k == 2 + rcd || k == 3 + rcd)) chk("R9 dq_out", int'(dq_out), wd);
         if (k <= 1 + rcd)      chk("R6 R12 row addr", int'(ma), row);
         else if (k <= 3 + rcd) chk("R7 R12 col addr", int'(ma), col);
         else                   chk("R7 idle addr", int'(ma), 0);
         if (k == 4 + rcd && !wr) chk("R10 rdata", int'(rdata), rd);
         #2;
         if (k == 1) chk("R4 ras after mid edge", int'(ras_n), 0);
         if (k < 4 + rcd) @(posedge clk);
      end
      @(negedge clk);
      chk("R11 ack pulse ends", int'(ack), 0);
   endtask

   initial begin
      #9;
      chk("R1 ras_n", int'(ras_n), 1);
      chk("R1 cas_n", int'(cas_n), 1);
      chk("R1 we_n", int'(we_n), 1);
      chk("R1 dq_oe", int'(dq_oe), 0);
      chk("R1 ack", int'(ack), 0);
      chk("R1 ma", int'(ma), 0);
      @(negedge clk);
      rst_n = 1'b1;
      begin
         int n;
         n = 0;
         for (int rcd = 0; rcd < 4; rcd++)
            for (int e = 0; e < 2; e++)
               for (int w = 0; w < 2; w++)
                  for (int rep = 0; rep < 2; rep++) begin
                     run_access(rcd, e[0], w[0], n);
                     n++;
                  end
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule